// File: doc/BRIEF.md
# Vector ALU Instruction Word Decoder

This block sits in an instruction fetch path and turns a stream of 32-bit words into decoded two-operand vector ALU instructions. Words enter through a valid/ready handshake. Each instruction word is split into an opcode, a destination vector register, a second-source vector register and a 9-bit first-source code. The first-source code is resolved into an operand descriptor that gives the operand class (scalar register, vector register, inline constant, literal or unsupported), the register index where one applies, and the 32-bit value where a constant applies.

When the first-source code requests a literal, the decoder holds the partial decode and emits nothing. It takes the next accepted word as the 32-bit constant and then presents the complete instruction. A word whose most significant bit is set does not belong to this encoding. It is passed through at once with a format error flag and never starts a literal fetch. The decoded instruction stays on a registered output until the consumer accepts it, and input ready drops while that slot is full.

Top module: `valu_decoder`

## Requirements
- R1: Field positions are fixed: opcode in bits 30:25, destination vector register in bits 24:17, second-source vector register in bits 16:9, first-source code in bits 8:0. For example, 0x4A000000 decodes to opcode 0x25, destination 0, second source 0, first source scalar register 0.
- R2: A word with bit 31 set is emitted on its own with the format error flag high, even when its first-source code is 0xFF. The next word is decoded as a new instruction.
- R3: First-source codes 0 to 127 give operand class 0 (scalar register), with the register index equal to the code and a value of 0.
- R4: First-source codes 256 to 511 give operand class 1 (vector register), with the register index equal to the code minus 256 and a value of 0.
- R5: Codes 128 to 192 give operand class 2 (inline constant) with the value equal to the code minus 128. Codes 193 to 208 give class 2 with the values -1 down to -16, sign-extended to 32 bits. The register index is 0.
- R6: Code 0xFF gives operand class 3 (literal). The output stays invalid after the instruction word is accepted. The next accepted word becomes the 32-bit value and is not decoded as an instruction. For example, 0x4A0202FF followed by 0x00000063 decodes to opcode 0x25, destination 1, second source 1, literal 0x63.
- R7: Codes 209 to 254 give operand class 4 (unsupported), with the operand error flag high and a value and index of 0.
- R8: Output valid rises in the cycle after the clock edge at which the final word of an instruction is accepted.
- R9: While output valid is high and output ready is low, input ready is low and every output holds its value. When the output is empty, input ready is high.
- R10: Synchronous reset clears output valid and abandons any pending literal fetch, so the first word after reset is decoded as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_data | input | 32 | Instruction or literal word |
| out_valid | output | 1 | Decoded instruction present |
| out_ready | input | 1 | Consumer accepts decoded instruction |
| out_opcode | output | 6 | Opcode |
| out_vdst | output | 8 | Destination vector register |
| out_vsrc1 | output | 8 | Second-source vector register |
| out_src0_kind | output | 3 | Operand class: 0 scalar, 1 vector, 2 inline, 3 literal, 4 unsupported |
| out_src0_reg | output | 8 | Register index of the first source |
| out_src0_value | output | 32 | Constant value of the first source |
| out_fmt_err | output | 1 | Word is not of this encoding |
| out_opnd_err | output | 1 | First-source code unsupported |

## Verification
The bench builds the decoder with its default inline-constant span, 64 positive and 16 negative values. With that span the boundary codes 128, 192, 193, 208 and 209 all fall between the register range and the literal escape code, so every edge of R5 and R7 can be reached with directed words. Random words spread over all five operand classes and include some with bit 31 set. Directed sequences cover stalls under backpressure and a reset taken during a pending literal fetch.

// File: rtl/valu_dec_pkg.sv
package valu_dec_pkg;

    localparam int WORD_W    = 32;
    localparam int OPC_W     = 6;
    localparam int VREG_W    = 8;
    localparam int SRC_W     = 9;

    localparam int SRC_LSB   = 0;
    localparam int VSRC1_LSB = SRC_LSB + SRC_W;
    localparam int VDST_LSB  = VSRC1_LSB + VREG_W;
    localparam int OPC_LSB   = VDST_LSB + VREG_W;
    localparam int FMT_BIT   = OPC_LSB + OPC_W;

    localparam int INL_ZERO  = 128;
    localparam logic [SRC_W-1:0] CODE_LITERAL = SRC_W'(255);

    typedef enum logic [2:0] {
        SRC_SREG   = 3'd0,
        SRC_VREG   = 3'd1,
        SRC_INLINE = 3'd2,
        SRC_LIT    = 3'd3,
        SRC_UNSUP  = 3'd4
    } src_kind_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [VREG_W-1:0] vdst;
        logic [VREG_W-1:0] vsrc1;
        src_kind_e         kind;
        logic [VREG_W-1:0] sreg;
        logic [WORD_W-1:0] value;
        logic              fmt_err;
        logic              opnd_err;
    } dec_t;

endpackage

// File: rtl/valu_field_split.sv
module valu_field_split
    import valu_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              fmt_bit,
    output logic [OPC_W-1:0]  opcode,
    output logic [VREG_W-1:0] vdst,
    output logic [VREG_W-1:0] vsrc1,
    output logic [SRC_W-1:0]  src0
);
    assign fmt_bit = word[FMT_BIT];
    assign opcode  = word[OPC_LSB   +: OPC_W];
    assign vdst    = word[VDST_LSB  +: VREG_W];
    assign vsrc1   = word[VSRC1_LSB +: VREG_W];
    assign src0    = word[SRC_LSB   +: SRC_W];
endmodule

// File: rtl/valu_src_resolve.sv
module valu_src_resolve
    import valu_dec_pkg::*;
#(
    parameter int POS_MAX = 64,
    parameter int NEG_MAX = 16
) (
    input  logic [SRC_W-1:0]  code,
    output src_kind_e         kind,
    output logic [VREG_W-1:0] sreg,
    output logic [WORD_W-1:0] value,
    output logic              opnd_err
);
    localparam int POS_TOP = INL_ZERO + POS_MAX;
    localparam int NEG_TOP = POS_TOP + NEG_MAX;

    int c;

    always_comb begin
        c        = int'(code);
        kind     = SRC_UNSUP;
        sreg     = '0;
        value    = '0;
        opnd_err = 1'b0;
        if (code[SRC_W-1]) begin
            kind = SRC_VREG;
            sreg = code[VREG_W-1:0];
        end else if (code == CODE_LITERAL) begin
            kind = SRC_LIT;
        end else if (c < INL_ZERO) begin
            kind = SRC_SREG;
            sreg = code[VREG_W-1:0];
        end else if (c <= POS_TOP) begin
            kind  = SRC_INLINE;
            value = WORD_W'(c - INL_ZERO);
        end else if (c <= NEG_TOP) begin
            kind  = SRC_INLINE;
            value = WORD_W'(POS_TOP - c);
        end else begin
            opnd_err = 1'b1;
        end
    end
endmodule

// File: rtl/valu_decoder.sv
module valu_decoder
    import valu_dec_pkg::*;
#(
    parameter int POS_MAX = 64,
    parameter int NEG_MAX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [VREG_W-1:0] out_vdst,
    output logic [VREG_W-1:0] out_vsrc1,
    output logic [2:0]        out_src0_kind,
    output logic [VREG_W-1:0] out_src0_reg,
    output logic [WORD_W-1:0] out_src0_value,
    output logic              out_fmt_err,
    output logic              out_opnd_err
);
    logic              f_fmt;
    logic [OPC_W-1:0]  f_opc;
    logic [VREG_W-1:0] f_vdst;
    logic [VREG_W-1:0] f_vsrc1;
    logic [SRC_W-1:0]  f_src0;
    src_kind_e         r_kind;
    logic [VREG_W-1:0] r_sreg;
    logic [WORD_W-1:0] r_value;
    logic              r_err;

    valu_field_split i_split (
        .word    (in_data),
        .fmt_bit (f_fmt),
        .opcode  (f_opc),
        .vdst    (f_vdst),
        .vsrc1   (f_vsrc1),
        .src0    (f_src0)
    );

    valu_src_resolve #(.POS_MAX(POS_MAX), .NEG_MAX(NEG_MAX)) i_resolve (
        .code     (f_src0),
        .kind     (r_kind),
        .sreg     (r_sreg),
        .value    (r_value),
        .opnd_err (r_err)
    );

    dec_t fresh;
    dec_t pend_q;
    dec_t out_q;
    logic wait_lit_q;
    logic acc;

    always_comb begin
        fresh.opcode   = f_opc;
        fresh.vdst     = f_vdst;
        fresh.vsrc1    = f_vsrc1;
        fresh.kind     = r_kind;
        fresh.sreg     = r_sreg;
        fresh.value    = r_value;
        fresh.fmt_err  = f_fmt;
        fresh.opnd_err = r_err;
    end

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_lit_q <= 1'b0;
            out_valid  <= 1'b0;
            out_q      <= '0;
            pend_q     <= '0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (acc) begin
                if (wait_lit_q) begin
                    out_q       <= pend_q;
                    out_q.value <= in_data;
                    out_valid   <= 1'b1;
                    wait_lit_q  <= 1'b0;
                end else if (!fresh.fmt_err && fresh.kind == SRC_LIT) begin
                    pend_q     <= fresh;
                    wait_lit_q <= 1'b1;
                end else begin
                    out_q     <= fresh;
                    out_valid <= 1'b1;
                end
            end
        end
    end

    assign out_opcode     = out_q.opcode;
    assign out_vdst       = out_q.vdst;
    assign out_vsrc1      = out_q.vsrc1;
    assign out_src0_kind  = out_q.kind;
    assign out_src0_reg   = out_q.sreg;
    assign out_src0_value = out_q.value;
    assign out_fmt_err    = out_q.fmt_err;
    assign out_opnd_err   = out_q.opnd_err;
endmodule

// File: rtl/valu_decoder_chk.sv
module valu_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [5:0]  out_opcode,
    input logic [7:0]  out_vdst,
    input logic [7:0]  out_vsrc1,
    input logic [2:0]  out_src0_kind,
    input logic [7:0]  out_src0_reg,
    input logic [31:0] out_src0_value,
    input logic        out_fmt_err,
    input logic        out_opnd_err
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R9: a stalled output holds
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_vdst)
            && $stable(out_vsrc1) && $stable(out_src0_kind) && $stable(out_src0_reg)
            && $stable(out_src0_value) && $stable(out_fmt_err) && $stable(out_opnd_err)));

    // R9: empty output slot accepts input
    p_ready_free_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R5: inline constants are small signed numbers
    p_inline_span_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src0_kind == 3'd2) |->
            (out_src0_value[31:8] == 24'h0 || out_src0_value[31:8] == 24'hFFFFFF));

    // R7: operand error only with unsupported class
    p_opnd_err_kind_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_opnd_err) |-> (out_src0_kind == 3'd4));

    // R10: no output right after reset
    always @(posedge clk) begin
        if (rst_q && !rst) begin
            p_reset_idle_r10: assert (!out_valid);
        end
    end

    logic unused_ok;
    assign unused_ok = ^{in_valid, in_data, out_vdst, out_vsrc1, out_src0_reg};
endmodule

bind valu_decoder valu_decoder_chk i_chk (.*);

// File: tb/test_valu_decoder.sv
`timescale 1ns/1ps
module test_valu_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [5:0]  out_opcode;
    logic [7:0]  out_vdst;
    logic [7:0]  out_vsrc1;
    logic [2:0]  out_src0_kind;
    logic [7:0]  out_src0_reg;
    logic [31:0] out_src0_value;
    logic        out_fmt_err;
    logic        out_opnd_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0]  e_opc;
    logic [7:0]  e_vdst, e_vs1, e_reg;
    logic [2:0]  e_kind;
    logic [31:0] e_val;
    logic        e_fe, e_oe;

    always #10 clk = ~clk;

    valu_decoder i_valu_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
        .out_vdst(out_vdst), .out_vsrc1(out_vsrc1), .out_src0_kind(out_src0_kind),
        .out_src0_reg(out_src0_reg), .out_src0_value(out_src0_value),
        .out_fmt_err(out_fmt_err), .out_opnd_err(out_opnd_err)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // expected decode computed from the requirements
    task automatic model(logic [31:0] w, logic [31:0] lit);
        int c;
        c      = int'(w[8:0]);
        e_fe   = w[31];
        e_opc  = w[30:25];
        e_vdst = w[24:17];
        e_vs1  = w[16:9];
        e_reg  = 8'd0;
        e_val  = 32'd0;
        e_oe   = 1'b0;
        if (c >= 256) begin
            e_kind = 3'd1; e_reg = 8'(c - 256);
        end else if (c == 255) begin
            e_kind = 3'd3; e_val = w[31] ? 32'd0 : lit;
        end else if (c < 128) begin
            e_kind = 3'd0; e_reg = 8'(c);
        end else if (c <= 192) begin
            e_kind = 3'd2; e_val = 32'(c - 128);
        end else if (c <= 208) begin
            e_kind = 3'd2; e_val = 32'(192 - c);
        end else begin
            e_kind = 3'd4; e_oe = 1'b1;
        end
    endtask

    task automatic check_out(string req);
        checks++;
        if (out_valid !== 1'b1 || out_opcode !== e_opc || out_vdst !== e_vdst ||
            out_vsrc1 !== e_vs1 || out_src0_kind !== e_kind || out_src0_reg !== e_reg ||
            out_src0_value !== e_val || out_fmt_err !== e_fe || out_opnd_err !== e_oe) begin
            failures++;
            $display("FAIL %s actual v=%0b opc=%h vd=%h vs=%h k=%0d r=%h val=%h fe=%0b oe=%0b expected v=1 opc=%h vd=%h vs=%h k=%0d r=%h val=%h fe=%0b oe=%0b",
                req, out_valid, out_opcode, out_vdst, out_vsrc1, out_src0_kind, out_src0_reg,
                out_src0_value, out_fmt_err, out_opnd_err,
                e_opc, e_vdst, e_vs1, e_kind, e_reg, e_val, e_fe, e_oe);
        end
    endtask

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic push(logic [31:0] w);
        logic rdy;
        in_data  = w;
        in_valid = 1'b1;
        forever begin
            #1 rdy = in_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
    endtask

    task automatic txn(string req, logic [31:0] w, logic [31:0] lit);
        model(w, lit);
        push(w);
        if (!w[31] && w[8:0] == 9'h0FF) begin
            check_bit({req, " R6 no output while waiting for literal"}, out_valid, 1'b0);
            @(negedge clk);
            push(lit);
        end
        check_out({req, " R8"});
        @(negedge clk);
    endtask

    function automatic logic [31:0] rand_word(output string req);
        logic [8:0] code;
        int cat;
        cat = int'($urandom % 6);
        case (cat)
            0: begin code = 9'($urandom % 128);       req = "R3"; end
            1: begin code = 9'(256 + $urandom % 256); req = "R4"; end
            2: begin code = 9'(128 + $urandom % 65);  req = "R5"; end
            3: begin code = 9'(193 + $urandom % 16);  req = "R5"; end
            4: begin code = 9'h0FF;                   req = "R6"; end
            default: begin code = 9'(209 + $urandom % 46); req = "R7"; end
        endcase
        rand_word = {($urandom % 16) == 0, 6'($urandom), 8'($urandom), 8'($urandom), code};
        if (rand_word[31]) req = "R2";
    endfunction

    initial begin
        string rq;
        logic [31:0] w;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        check_bit("R10 reset clears output valid", out_valid, 1'b0);
        check_bit("R9 ready when empty", in_ready, 1'b1);
        rst = 1'b0;
        @(negedge clk);

        txn("R1 R3 plain word", 32'h4A000000, 32'd0);
        txn("R1 R6 literal pair", 32'h4A0202FF, 32'h00000063);
        txn("R4 vector reg 0", 32'h4A020300, 32'd0);
        txn("R5 inline zero", 32'h4A020280, 32'd0);
        txn("R5 inline 64", 32'h4A0202C0, 32'd0);
        txn("R5 inline -1", 32'h4A0202C1, 32'd0);
        txn("R5 inline -16", 32'h4A0202D0, 32'd0);
        txn("R7 code 209", 32'h4A0202D1, 32'd0);
        txn("R7 code 254", 32'h4A0202FE, 32'd0);
        txn("R3 scalar 127", 32'h0000007F, 32'd0);
        txn("R2 format error with literal code", 32'hCA0202FF, 32'd0);
        txn("R2 next word decoded after error", 32'h4A000000, 32'd0);
        txn("R6 literal all ones", 32'h7FFFFEFF, 32'hFFFFFFFF);

        // R9 backpressure
        out_ready = 1'b0;
        model(32'h4A000000, 32'd0);
        push(32'h4A000000);
        check_bit("R9 ready low while stalled", in_ready, 1'b0);
        in_data  = 32'h4C0A0481;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check_out("R9 output held while stalled");
        check_bit("R9 ready still low", in_ready, 1'b0);
        out_ready = 1'b1;
        model(32'h4C0A0481, 32'd0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check_out("R9 queued word decoded after release");
        @(negedge clk);

        // R10 reset during literal wait
        push(32'h4A0202FF);
        check_bit("R10 waiting for literal", out_valid, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_bit("R10 output clear after reset", out_valid, 1'b0);
        txn("R10 first word after reset is an instruction", 32'h4A000000, 32'd0);

        for (int i = 0; i < 400; i++) begin
            w = rand_word(rq);
            txn({rq, " random"}, w, $urandom);
        end
        summary();
    end
endmodule